// File: doc/BRIEF.md
# I2C Target Interface with Clock Stretching

This block is a standard-mode I2C target that answers to a 7-bit address held on an input. It watches the bus for START, repeated START and STOP. After each START it shifts in the first byte: the upper seven bits are compared with its own address, and the lowest bit selects the direction. When the address matches, the target either receives data bytes and hands each one to local logic, or fetches bytes from local logic and shifts them out to the controller.

Local logic paces the transfer with two inputs. `local_ready` low makes the target hold SCL low before it decides an acknowledge, and also before it loads a byte to send, so the controller waits. `take_ok` decides whether the target answers the address, or a received data byte, with ACK (SDA low) or NACK (SDA released). Both bus lines are open-drain. Each output is an enable that pulls its line low when 1 and releases it to the pull-up when 0. SCL and SDA are synchronised into the system clock domain, so that clock must run many times faster than SCL.

Top module: `i2c_target`

## Requirements
- R1: The first byte after a START carries the address in bits 7..1 and the direction in bit 0 (1 = controller reads, 0 = controller writes). When bits 7..1 equal `own_addr` and `take_ok` is 1, the target drives SDA low for the whole ninth clock.
- R2: When the address bits differ from `own_addr`, SDA stays released in the ninth clock. Every following clock is ignored, with no SDA drive and no strobe, until the next START.
- R3: When the address matches but `take_ok` is 0 at the acknowledge decision, SDA stays released in the ninth clock, and the target ignores the bus until the next START.
- R4: In a write transfer, data bits are taken MSB first on SCL rising edges, and any number of bytes can follow the address. When `take_ok` is 1, a byte is acknowledged and `rx_valid` pulses for exactly one cycle with the byte on `rx_data`. When `take_ok` is 0, the byte gets a NACK, there is no strobe, and the target goes idle.
- R5: After the eighth falling SCL edge of a byte it will acknowledge, and before it loads a byte to send, the target holds SCL low for as long as `local_ready` is 0. It releases SCL only after `local_ready` returns to 1.
- R6: In a read transfer, `tx_req` pulses for one cycle as `tx_data` is loaded, and the byte goes out MSB first. The SDA drive changes only while SCL is low, and SDA is released during the controller's acknowledge clock. `rx_valid` and `tx_req` are never high in the same cycle.
- R7: When the controller leaves SDA high in its acknowledge clock, the target sends nothing further: no more `tx_req` pulses, and SDA stays released.
- R8: A START at any point, including partway through a byte, throws away the partial byte and restarts address reception. A STOP returns the target to idle, where clocks without a START are ignored.
- R9: While `rst` is high and in the cycle after it, both line enables are 0 and neither strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| own_addr | input | 7 | Address the target answers to |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (stretching) |
| sda_oe | output | 1 | 1 pulls SDA low (ACK or data 0) |
| take_ok | input | 1 | 1 = acknowledge the address or the current received byte |
| local_ready | input | 1 | 0 = stretch SCL at the acknowledge decision or at byte load |
| rx_data | output | 8 | Last acknowledged received byte |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| tx_data | input | 8 | Byte to send next |
| tx_req | output | 1 | One-cycle strobe when `tx_data` is taken |

## Verification
The assertions assume the controller holds SCL low for far longer than the synchroniser and edge-detect delay. The target's SDA changes and stretch holds must land inside that low phase, so a bus edge is never seen late. They also assume the controller never issues a START or STOP while the target is driving SDA. The bench models the controller with 20 system cycles per SCL half-period. It changes its own SDA only halfway through SCL low, waits for the wired-AND SCL level to rise before timing the high phase, and sends START and STOP only when the target has released SDA.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WRITE,
    ST_ACK_WAIT,
    ST_ACK_SLOT,
    ST_TX_LOAD,
    ST_TX_BITS,
    ST_MACK
  } tgt_state_e;

  typedef struct packed {
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
    logic sda;
  } bus_ev_t;

endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '1;
    else     pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/i2ct_bus_events.sv
module i2ct_bus_events
  import i2ct_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    scl_s,
  input  logic    sda_s,
  output bus_ev_t ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_comb begin
    ev.scl_rise = scl_s & ~scl_q;
    ev.scl_fall = ~scl_s & scl_q;
    ev.start    = scl_s & scl_q & sda_q & ~sda_s;
    ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
    ev.sda      = sda_s;
  end
endmodule

// File: rtl/i2ct_engine.sv
module i2ct_engine
  import i2ct_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] own_addr,
  input  bus_ev_t           ev,
  input  logic              take_ok,
  input  logic              local_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              tx_req
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

  tgt_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] shreg;
  logic              is_addr, rd_mode, acked, mack_ok;
  logic              addr_hit;

  assign addr_hit = (shreg[DATA_W-1 -: ADDR_W] == own_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      shreg    <= '0;
      is_addr  <= 1'b0;
      rd_mode  <= 1'b0;
      acked    <= 1'b0;
      mack_ok  <= 1'b0;
      scl_oe   <= 1'b0;
      sda_oe   <= 1'b0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      tx_req   <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      tx_req   <= 1'b0;
      if (ev.start) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
        scl_oe <= 1'b0;
      end else if (ev.stop) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
        scl_oe <= 1'b0;
      end else begin
        case (state)
          ST_IDLE: begin
            sda_oe <= 1'b0;
            scl_oe <= 1'b0;
          end
          ST_ADDR, ST_WRITE: begin
            scl_oe <= 1'b0;
            if (ev.scl_rise && cnt != FULL) begin
              shreg <= {shreg[DATA_W-2:0], ev.sda};
              cnt   <= cnt + 1'b1;
            end else if (ev.scl_fall && cnt == FULL) begin
              if (state == ST_ADDR && !addr_hit) begin
                state <= ST_IDLE;
              end else begin
                state   <= ST_ACK_WAIT;
                is_addr <= (state == ST_ADDR);
                if (state == ST_ADDR) rd_mode <= shreg[0];
              end
            end
          end
          ST_ACK_WAIT: begin
            // SDA settles one cycle before a held SCL is let go
            if (local_ready) begin
              sda_oe <= take_ok;
              acked  <= take_ok;
              state  <= ST_ACK_SLOT;
              if (!is_addr && take_ok) begin
                rx_valid <= 1'b1;
                rx_data  <= shreg;
              end
            end else begin
              scl_oe <= 1'b1;
            end
          end
          ST_ACK_SLOT: begin
            scl_oe <= 1'b0;
            if (ev.scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              if (!acked)                  state <= ST_IDLE;
              else if (is_addr && rd_mode) state <= ST_TX_LOAD;
              else                         state <= ST_WRITE;
            end
          end
          ST_TX_LOAD: begin
            if (local_ready) begin
              shreg  <= tx_data;
              sda_oe <= ~tx_data[DATA_W-1];
              tx_req <= 1'b1;
              cnt    <= '0;
              state  <= ST_TX_BITS;
            end else begin
              scl_oe <= 1'b1;
            end
          end
          ST_TX_BITS: begin
            scl_oe <= 1'b0;
            if (ev.scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (ev.scl_fall) begin
              if (cnt == FULL) begin
                sda_oe <= 1'b0;
                state  <= ST_MACK;
              end else begin
                shreg  <= {shreg[DATA_W-2:0], 1'b0};
                sda_oe <= ~shreg[DATA_W-2];
              end
            end
          end
          ST_MACK: begin
            scl_oe <= 1'b0;
            sda_oe <= 1'b0;
            if (ev.scl_rise)      mack_ok <= ~ev.sda;
            else if (ev.scl_fall) state   <= mack_ok ? ST_TX_LOAD : ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_target.sv
module i2c_target
  import i2ct_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              take_ok,
  input  logic              local_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_req
);
  logic [1:0] lines_s;
  bus_ev_t    ev;

  i2ct_sync #(.W(2), .STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rst (rst),
    .d   ({scl_i, sda_i}),
    .q   (lines_s)
  );

  i2ct_bus_events events_i (
    .clk   (clk),
    .rst   (rst),
    .scl_s (lines_s[1]),
    .sda_s (lines_s[0]),
    .ev    (ev)
  );

  i2ct_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) engine_i (
    .clk         (clk),
    .rst         (rst),
    .own_addr    (own_addr),
    .ev          (ev),
    .take_ok     (take_ok),
    .local_ready (local_ready),
    .tx_data     (tx_data),
    .scl_oe      (scl_oe),
    .sda_oe      (sda_oe),
    .rx_data     (rx_data),
    .rx_valid    (rx_valid),
    .tx_req      (tx_req)
  );
endmodule

// File: rtl/i2ct_checker.sv
module i2ct_checker (
  input logic clk,
  input logic rst,
  input logic scl_i,
  input logic scl_oe,
  input logic sda_oe,
  input logic local_ready,
  input logic rx_valid,
  input logic tx_req
);
  // R9
  rst_release_chk: assert property (@(posedge clk)
    rst |=> (!scl_oe && !sda_oe && !rx_valid && !tx_req));

  // R4
  rx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R6
  tx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tx_req |=> !tx_req);

  // R6
  sda_change_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_i);

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rx_valid && tx_req));

  // R5
  stretch_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_oe) |-> $past(!local_ready));
endmodule

bind i2c_target i2ct_checker chk_i (
  .clk         (clk),
  .rst         (rst),
  .scl_i       (scl_i),
  .scl_oe      (scl_oe),
  .sda_oe      (sda_oe),
  .local_ready (local_ready),
  .rx_valid    (rx_valid),
  .tx_req      (tx_req)
);

// File: tb/i2c_target_tb_top.sv
`timescale 1ns/1ps
module i2c_target_tb_top;
  localparam int HP = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] own_addr = 7'h5A;
  logic       take_ok = 1'b1;
  logic       local_ready = 1'b1;
  logic [7:0] tx_data = 8'h00;
  logic       scl_oe, sda_oe, rx_valid, tx_req;
  logic [7:0] rx_data;
  logic       m_scl_low = 1'b0;
  logic       m_sda_low = 1'b0;
  logic       scl_line, sda_line;

  int total = 0;
  int bad = 0;
  int stretch_acc = 0;
  int tx_pops = 0;
  int sda_glitch = 0;
  bit done = 1'b0;
  logic prev_sda_oe = 1'b0;
  logic [7:0] rx_q[$];
  logic [7:0] tx_q[$];

  always #2 clk = ~clk;

  assign scl_line = !(m_scl_low || scl_oe);
  assign sda_line = !(m_sda_low || sda_oe);

  i2c_target dut_i (
    .clk(clk), .rst(rst), .own_addr(own_addr), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .take_ok(take_ok), .local_ready(local_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .tx_data(tx_data), .tx_req(tx_req)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: scoreboard for received bytes, transmit queue, SDA timing
  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid) begin
        if (rx_q.size() == 0) check("R4", "unexpected rx strobe", int'(rx_data), -1);
        else check("R4", "received byte", int'(rx_data), int'(rx_q.pop_front()));
      end
      if (tx_req) begin
        tx_pops++;
        if (tx_q.size() > 0) void'(tx_q.pop_front());
      end
      if (sda_oe != prev_sda_oe && scl_line) sda_glitch++;
    end
    prev_sda_oe = sda_oe;
    tx_data = (tx_q.size() > 0) ? tx_q[0] : 8'h00;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic m_clock(output logic v);
    m_scl_low = 1'b0;
    @(negedge clk);
    while (!scl_line) begin
      @(negedge clk);
      stretch_acc++;
    end
    wait_clk(HP / 2);
    v = sda_line;
    wait_clk(HP / 2);
    m_scl_low = 1'b1;
    wait_clk(HP / 2);
  endtask

  task automatic m_bit(input logic b);
    logic v;
    m_sda_low = !b;
    wait_clk(HP / 2);
    m_clock(v);
  endtask

  task automatic m_start();
    m_sda_low = 1'b0;
    wait_clk(HP / 2);
    m_scl_low = 1'b0;
    @(negedge clk);
    while (!scl_line) @(negedge clk);
    wait_clk(HP / 2);
    m_sda_low = 1'b1;
    wait_clk(HP / 2);
    m_scl_low = 1'b1;
    wait_clk(HP / 2);
  endtask

  task automatic m_stop();
    m_sda_low = 1'b1;
    wait_clk(HP / 2);
    m_scl_low = 1'b0;
    @(negedge clk);
    while (!scl_line) @(negedge clk);
    wait_clk(HP / 2);
    m_sda_low = 1'b0;
    wait_clk(HP);
  endtask

  task automatic m_write(input logic [7:0] b, output logic ack);
    logic v;
    for (int i = 7; i >= 0; i--) m_bit(b[i]);
    m_sda_low = 1'b0;
    wait_clk(HP / 2);
    m_clock(v);
    ack = !v;
  endtask

  task automatic m_read(input logic give_ack, output logic [7:0] d);
    logic v;
    m_sda_low = 1'b0;
    for (int i = 0; i < 8; i++) begin
      wait_clk(HP / 2);
      m_clock(v);
      d = {d[6:0], v};
    end
    m_sda_low = give_ack;
    wait_clk(HP / 2);
    m_clock(v);
    m_sda_low = 1'b0;
  endtask

  task automatic raise_ready_after(input int n);
    fork
      begin
        @(negedge clk);
        while (!scl_oe) @(negedge clk);
        wait_clk(n);
        local_ready = 1'b1;
      end
    join_none
  endtask

  task automatic run_all();
    logic ack;
    logic [7:0] d;

    wait_clk(5);
    rst = 1'b0;
    @(negedge clk);
    // R9: released outputs right after reset
    check("R9", "scl_oe after reset", int'(scl_oe), 0);
    check("R9", "sda_oe after reset", int'(sda_oe), 0);
    check("R9", "strobes after reset", int'({rx_valid, tx_req}), 0);
    wait_clk(20);

    // R1, R4: matched write, three bytes
    m_start();
    m_write({7'h5A, 1'b0}, ack);
    check("R1", "address ack", int'(ack), 1);
    foreach (rx_q[i]) ;
    rx_q.push_back(8'hA5); m_write(8'hA5, ack); check("R4", "byte0 ack", int'(ack), 1);
    rx_q.push_back(8'h3C); m_write(8'h3C, ack); check("R4", "byte1 ack", int'(ack), 1);
    rx_q.push_back(8'hFF); m_write(8'hFF, ack); check("R4", "byte2 ack", int'(ack), 1);
    m_stop();
    check("R4", "rx queue drained", rx_q.size(), 0);

    // R2: other address is not acknowledged and following clocks are ignored
    m_start();
    m_write({7'h22, 1'b0}, ack);
    check("R2", "foreign address nack", int'(ack), 0);
    m_write(8'h00, ack);
    check("R2", "byte after foreign address ignored", int'(ack), 0);
    m_stop();

    // R3: own address refused when take_ok is low
    take_ok = 1'b0;
    m_start();
    m_write({7'h5A, 1'b0}, ack);
    check("R3", "refused address nack", int'(ack), 0);
    take_ok = 1'b1;
    m_write(8'h00, ack);
    check("R3", "idle after refusal", int'(ack), 0);
    m_stop();

    // R4: data byte refused, no strobe
    m_start();
    m_write({7'h5A, 1'b0}, ack);
    check("R1", "address ack before refusal", int'(ack), 1);
    take_ok = 1'b0;
    m_write(8'h77, ack);
    check("R4", "refused data nack", int'(ack), 0);
    take_ok = 1'b1;
    m_stop();

    // R5: stretch before acknowledging a written byte
    m_start();
    m_write({7'h5A, 1'b0}, ack);
    local_ready = 1'b0;
    raise_ready_after(300);
    stretch_acc = 0;
    rx_q.push_back(8'h6B);
    m_write(8'h6B, ack);
    check("R5", "stretched byte ack", int'(ack), 1);
    check("R5", "stretch long enough", int'(stretch_acc >= 250), 1);
    m_stop();
    check("R5", "rx after stretch", rx_q.size(), 0);

    // R6, R7: read three bytes, stretch at the address, NACK on last
    tx_pops = 0;
    tx_q.push_back(8'hC3); tx_q.push_back(8'h81); tx_q.push_back(8'h7E);
    local_ready = 1'b0;
    raise_ready_after(200);
    stretch_acc = 0;
    m_start();
    m_write({7'h5A, 1'b1}, ack);
    check("R1", "read address ack", int'(ack), 1);
    check("R5", "read stretch long enough", int'(stretch_acc >= 150), 1);
    m_read(1'b1, d); check("R6", "read byte0", int'(d), 'hC3);
    m_read(1'b1, d); check("R6", "read byte1", int'(d), 'h81);
    m_read(1'b0, d); check("R6", "read byte2", int'(d), 'h7E);
    wait_clk(200);
    check("R7", "no tx_req after nack", tx_pops, 3);
    check("R7", "sda released after nack", int'(sda_line), 1);
    m_stop();

    // R8: repeated START from write to read
    tx_pops = 0;
    m_start();
    m_write({7'h5A, 1'b0}, ack);
    rx_q.push_back(8'h11);
    m_write(8'h11, ack);
    check("R8", "byte before restart", int'(ack), 1);
    tx_q.push_back(8'h99);
    m_start();
    m_write({7'h5A, 1'b1}, ack);
    check("R8", "address after restart", int'(ack), 1);
    m_read(1'b0, d);
    check("R8", "read after restart", int'(d), 'h99);
    m_stop();

    // R8: START in the middle of a byte drops the partial byte
    m_start();
    m_write({7'h5A, 1'b0}, ack);
    m_bit(1'b1); m_bit(1'b0); m_bit(1'b1); m_bit(1'b0);
    m_start();
    m_write({7'h5A, 1'b0}, ack);
    check("R8", "address after mid-byte start", int'(ack), 1);
    rx_q.push_back(8'h42);
    m_write(8'h42, ack);
    m_stop();
    check("R8", "only full byte delivered", rx_q.size(), 0);

    // R8: after STOP, clocks without START are ignored
    m_write({7'h5A, 1'b0}, ack);
    check("R8", "no ack without start", int'(ack), 0);
    m_start();
    m_stop();

    check("R6", "sda changes only while scl low", sda_glitch, 0);
    check("R4", "no pending rx", rx_q.size(), 0);
  endtask

  initial begin
    run_all();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule